// File: doc/BRIEF.md
# APB Requester Transfer Sequencer

This block is the requesting side of an APB link. A local agent hands it one command at a time over a valid/ready handshake. Each command carries an address, a write flag and write data. The block turns each command into a bus transfer with two phases. The first is a single setup cycle, in which the select is raised and the enable is held low. The second is an access phase, in which the enable is high. The access phase lasts until the completer raises its ready. The block then reports the result with a one-cycle done pulse, together with the captured read data and the error flag.

The block drives a single select line. A new command can be taken in the same cycle as the completing access cycle, so transfers can follow one another with no idle cycle between them. Every bus output comes from a register or from the state register, and none of them changes while a transfer is in flight. Reset is asynchronous and active-low. The surrounding reset logic must release it synchronously to the clock.

Top module: `apb_xfer_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, psel, penable and rsp_done are low, cmd_ready is high, and rsp_rdata and rsp_err are zero.
- R2: A command is taken on a rising edge where cmd_valid and cmd_ready are both high. In the following cycle psel is 1 and penable is 0, and paddr, pwrite and pwdata equal the command's fields.
- R3: The setup cycle lasts exactly one cycle. It is followed by access cycles with psel and penable both high and the same address, direction and write data.
- R4: An access cycle with pready low is followed by another access cycle. There is no limit on how many such cycles occur. psel, penable, paddr, pwrite and pwdata do not change across them.
- R5: cmd_ready is high only in the idle state, or in an access cycle where pready is high. A command presented at any other time is not taken and leaves the bus outputs unchanged.
- R6: rsp_done is high for exactly one cycle, the cycle right after each access cycle with pready high, and is low at all other times.
- R7: On completion of a read (pwrite=0), rsp_rdata takes the prdata value present in the completing cycle. prdata in any other cycle is ignored. Completing a write leaves rsp_rdata unchanged.
- R8: On every completion, rsp_err takes the pslverr value of the completing cycle and keeps it until the next completion.
- R9: If a command is taken in the completing access cycle, the next cycle is a setup cycle with no idle cycle in between. Otherwise the next cycle is idle, with psel and penable both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_addr | input | ADDR_W | Command address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DATA_W | Command write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data of the last completed read |
| rsp_err | output | 1 | Error flag of the last completed transfer |
| psel | output | 1 | Bus select |
| penable | output | 1 | Bus enable (access phase) |
| paddr | output | ADDR_W | Bus address |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DATA_W | Bus write data |
| pready | input | 1 | Completer ready |
| prdata | input | DATA_W | Completer read data |
| pslverr | input | 1 | Completer error |

## Verification
The assertions assume the following about the inputs:
- A completer may drive any value on pready, prdata and pslverr outside an access cycle.
- Reset deassertion is aligned to the clock.

The stimulus drives junk values on these three lines whenever no access phase is active, and during wait cycles inside one. This shows that only the completing cycle is sampled. Each command stays on the command inputs until it is taken. Wait counts come from a seeded random draw, with a few forced cases: zero waits, a thirty-cycle stall, and commands held valid across a completion so that transfers run back to back.

// File: rtl/apbm_pkg.sv
package apbm_pkg;

  // Bus sequencing phases; idle is the reset value
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } apbm_state_e;

endpackage

// File: rtl/apbm_seq.sv
module apbm_seq
  import apbm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic pready,
  output logic cmd_ready,
  output logic take,
  output logic finish,
  output logic psel,
  output logic penable
);

  apbm_state_e state_q;
  apbm_state_e state_d;

  // next-state process
  always_comb begin
    finish    = (state_q == ST_ACCESS) && pready;
    cmd_ready = (state_q == ST_IDLE) || finish;
    take      = cmd_valid && cmd_ready;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE:   if (take) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: if (finish) state_d = take ? ST_SETUP : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign psel    = (state_q != ST_IDLE);
  assign penable = (state_q == ST_ACCESS);

  // R3
  setup_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP) |=> (state_q == ST_ACCESS))
    else $error("setup phase did not advance to access");

  // R4
  wait_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACCESS && !pready) |=> (state_q == ST_ACCESS))
    else $error("access phase left without ready");

endmodule

// File: rtl/apbm_hold.sv
module apbm_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              penable,
  input  logic              pready,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;

  // load enable: only when a command is taken
  always_comb begin
    addr_d = addr_q;
    wr_d   = wr_q;
    wdat_d = wdat_q;
    if (take) begin
      addr_d = cmd_addr;
      wr_d   = cmd_write;
      wdat_d = cmd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      wdat_q <= '0;
    end else begin
      addr_q <= addr_d;
      wr_q   <= wr_d;
      wdat_q <= wdat_d;
    end
  end

  assign paddr  = addr_q;
  assign pwrite = wr_q;
  assign pwdata = wdat_q;

  // R4
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && !pready) |=> ($stable(paddr) && $stable(pwrite) && $stable(pwdata)))
    else $error("bus fields moved during a wait state");

endmodule

// File: rtl/apbm_resp.sv
module apbm_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              finish,
  input  logic              was_write,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  logic              done_q, done_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              err_q, err_d;

  always_comb begin
    done_d = finish;
    rdat_d = rdat_q;
    err_d  = err_q;
    if (finish) begin
      err_d = pslverr;
      if (!was_write) rdat_d = prdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      rdat_q <= '0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      rdat_q <= rdat_d;
      err_q  <= err_d;
    end
  end

  assign rsp_done  = done_q;
  assign rsp_rdata = rdat_q;
  assign rsp_err   = err_q;

  // R6
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> rsp_done)
    else $error("completion without done pulse");

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(finish))
    else $error("done pulse without completion");

  // R7
  write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && was_write) |=> $stable(rsp_rdata))
    else $error("write completion touched read data");

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(rsp_err))
    else $error("error flag moved without completion");

endmodule

// File: rtl/apb_xfer_master.sv
module apb_xfer_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              psel,
  output logic              penable,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic              pready,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr
);

  logic take;
  logic finish;

  apbm_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .pready    (pready),
    .cmd_ready (cmd_ready),
    .take      (take),
    .finish    (finish),
    .psel      (psel),
    .penable   (penable)
  );

  apbm_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .cmd_addr  (cmd_addr),
    .cmd_write (cmd_write),
    .cmd_wdata (cmd_wdata),
    .penable   (penable),
    .pready    (pready),
    .paddr     (paddr),
    .pwrite    (pwrite),
    .pwdata    (pwdata)
  );

  apbm_resp #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .finish    (finish),
    .was_write (pwrite),
    .prdata    (prdata),
    .pslverr   (pslverr),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  // R2
  setup_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (psel && !penable && paddr == $past(cmd_addr)
                                  && pwrite == $past(cmd_write)))
    else $error("taken command did not open a setup phase");

  // R3
  setup_to_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable))
    else $error("setup not followed by access");

  // R5
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !(penable && pready)) |-> !cmd_ready)
    else $error("command accepted mid-transfer");

  // R9
  idle_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && pready && !cmd_valid) |=> (!psel && !penable))
    else $error("bus not idle after lone completion");

endmodule

// File: tb/apb_xfer_master_test.sv
module apb_xfer_master_test;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int N  = 300;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic cmd_ready, rsp_done, rsp_err, psel, penable, pwrite;
  logic [DW-1:0] rsp_rdata, pwdata, prdata;
  logic [AW-1:0] paddr;
  logic pready, pslverr;

  always #4 clk = ~clk;

  apb_xfer_master #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite),
    .pwdata(pwdata), .pready(pready), .prdata(prdata), .pslverr(pslverr)
  );

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] c_addr [N];
  logic [DW-1:0] c_wdat [N];
  logic [DW-1:0] c_rd   [N];
  bit            c_wr   [N];
  bit            c_err  [N];
  int            c_wait [N];
  bit            c_b2b  [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ready per R5: idle, or completing access
  function automatic bit exp_ready(input int ph, input bit rdy);
    return (ph == 0) || (ph == 2 && rdy);
  endfunction

  function automatic logic [DW-1:0] mk_rd(input int i);
    return {16'(i * 37), 16'hA5C3} ^ 32'(i << 3);
  endfunction

  initial begin
    int phase, cur, nxt, acc_idx, done_cnt, waitcnt, cyc;
    bit acc_p, comp_p;
    logic [DW-1:0] last_rd;
    bit last_err;

    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < N; i++) begin
      c_addr[i] = $urandom & 32'hFFFF_FFFC;
      c_wdat[i] = $urandom;
      c_rd[i]   = mk_rd(i);
      c_wr[i]   = ($urandom % 2) == 1;
      c_err[i]  = ($urandom % 5) == 0;
      c_b2b[i]  = ($urandom % 3) != 0;
      if (i < 3)                c_wait[i] = 0;
      else if (i == 3)          c_wait[i] = 30;
      else if ($urandom % 8 == 0) c_wait[i] = $urandom % 12;
      else                      c_wait[i] = $urandom % 3;
    end
    c_wr[1] = 1'b0; c_wr[2] = 1'b1; c_wr[3] = 1'b0; c_err[3] = 1'b1;

    rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0;
    cmd_wdata = '0; pready = 1'b0; prdata = '0; pslverr = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!psel && !penable, "R1", "psel/penable in reset", {psel, penable}, 0);
    chk(!rsp_done, "R1", "done in reset", rsp_done, 0);
    chk(cmd_ready, "R1", "ready in reset", cmd_ready, 1);
    chk(rsp_rdata == 0 && !rsp_err, "R1", "response in reset", rsp_rdata, 0);
    rst_n = 1'b1;

    phase = 0; cur = 0; nxt = 0; acc_idx = 0; done_cnt = 0; waitcnt = 0;
    acc_p = 0; comp_p = 0; last_rd = '0; last_err = 0; cyc = 0;

    while (done_cnt < N) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(0, "WATCHDOG", "run hung", done_cnt, N);
        break;
      end
      if (cyc == 1) begin
        // R1 first cycle after reset
        chk(!psel && !penable && cmd_ready, "R1", "first cycle", {psel, penable, cmd_ready}, 1);
      end
      // bench model of phase
      if (comp_p) begin
        done_cnt++;
        if (!c_wr[cur]) last_rd = c_rd[cur];
        last_err = c_err[cur];
        phase = acc_p ? 1 : 0;
        if (acc_p) cur = acc_idx;
      end else if (acc_p) begin
        phase = 1; cur = acc_idx;
      end else if (phase == 1) begin
        phase = 2; waitcnt = 0;
      end

      // bus checks
      if (phase == 0) begin
        chk(!psel && !penable, "R9", "idle bus", {psel, penable}, 0);
      end else if (phase == 1) begin
        chk(psel && !penable, comp_p ? "R9" : "R2", "setup phase", {psel, penable}, 2'b10);
        chk(paddr == c_addr[cur] && pwrite == c_wr[cur] && pwdata == c_wdat[cur],
            "R2", "setup fields", paddr, c_addr[cur]);
      end else begin
        chk(psel && penable, "R3", "access phase", {psel, penable}, 2'b11);
        chk(paddr == c_addr[cur] && pwrite == c_wr[cur] && pwdata == c_wdat[cur],
            waitcnt == 0 ? "R3" : "R4", "access fields", pwdata, c_wdat[cur]);
      end
      chk(rsp_done == comp_p, "R6", "done pulse", rsp_done, comp_p);
      chk(rsp_rdata == last_rd, "R7", "read data", rsp_rdata, last_rd);
      chk(rsp_err == last_err, "R8", "error flag", rsp_err, last_err);

      // completer side
      if (phase == 2) begin
        pready  = (waitcnt >= c_wait[cur]);
        prdata  = pready ? c_rd[cur] : $urandom;
        pslverr = pready ? c_err[cur] : ($urandom % 2 == 1);
        waitcnt++;
      end else begin
        pready  = ($urandom % 2) == 1;
        prdata  = $urandom;
        pslverr = ($urandom % 2) == 1;
      end

      // requester side
      if (acc_p) cmd_valid = 1'b0;
      if (!cmd_valid && nxt < N && (c_b2b[nxt] || $urandom % 3 == 0)) begin
        cmd_valid = 1'b1;
        cmd_addr  = c_addr[nxt];
        cmd_write = c_wr[nxt];
        cmd_wdata = c_wdat[nxt];
      end else if (!cmd_valid) begin
        cmd_addr  = $urandom;
        cmd_wdata = $urandom;
        cmd_write = ($urandom % 2) == 1;
      end

      #1;
      chk(cmd_ready == exp_ready(phase, pready), "R5", "cmd_ready", cmd_ready,
          exp_ready(phase, pready));
      acc_p  = cmd_valid && exp_ready(phase, pready);
      comp_p = (phase == 2) && pready;
      if (acc_p) begin
        acc_idx = nxt;
        nxt++;
      end
    end

    // trailing idle: last done pulse and quiet bus
    @(negedge clk);
    if (comp_p && !c_wr[cur]) last_rd = c_rd[cur];
    chk(rsp_done == comp_p, "R6", "final done", rsp_done, comp_p);
    chk(rsp_rdata == last_rd, "R7", "final read data", rsp_rdata, last_rd);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(!psel && !penable && !rsp_done, "R9", "quiet end", {psel, penable, rsp_done}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule